// File: doc/BRIEF.md
# Three-Bank GPIO Controller with Pin Interrupts

This block is a memory-mapped general-purpose I/O controller with three banks of 30 pins each. For every pin, software chooses the direction and the driven level and reads back the sampled level. A per-pin enable decides whether the controller owns the pin. Each pin can also raise an interrupt, either while it holds a chosen level or once on a chosen edge. Each bank drives one interrupt line toward the system interrupt controller.

Software reaches the block through a single-cycle 32-bit register port. A read returns its data one cycle after the request. The registers are arranged in groups, one group per kind of register. Inside each group the banks sit at a 4-byte stride. Pin inputs are treated as asynchronous: they pass through a two-flop synchronizer before they are used for reads or for event detection.

Top module: `pio_multibank`

## Requirements
- R1: After reset every direction register reads 0x3FFFFFFF (all pins inputs), and every other register reads 0. `irq`, `pin_oe` and `pin_out` are all 0.
- R2: A register sits at address group×16 + bank×4. The groups are: direction 0x0, polarity 0x2, type 0x3, interrupt enable 0x4, status 0x5, pin enable 0x6, data in 0x7, data out 0x8. A read returns `rd_data` with `rd_valid` high in the next cycle. Bits 31:30 always read 0. A misaligned address, an unused group or bank index 3 reads as 0.
- R3: One cycle after a register write, `pin_oe` of a pin is (pin enable AND NOT direction) and `pin_out` is its data-out bit. Direction 1 means input.
- R4: Data in returns each pin's level through two synchronizer stages. Writes to data in have no effect.
- R5: With type bit 0 (level), a pin whose enable bit is 1 sets its status bit on every cycle its synchronized level equals its polarity bit. The status bit therefore sets again after a clear while the level persists.
- R6: With type bit 1 (edge), an enabled pin sets its status bit once per rising edge when polarity is 1, and once per falling edge when polarity is 0. A held level does not set the bit again.
- R7: Writing 0 to a status bit clears it. Writing 1 leaves it unchanged.
- R8: If an event and a clearing status write land in the same cycle, the status bit ends set.
- R9: `irq[b]` is registered and equals the OR over bank b's pins of (direction AND status AND interrupt enable). A pin set as an output therefore raises no interrupt.
- R10: A write to one bank leaves the registers and pins of the other banks unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte address |
| req_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid, one cycle after a read request |
| rd_data | output | 32 | Read data |
| pin_in | input | 90 | Pin levels, bank b at bits b×30 upward |
| pin_out | output | 90 | Driven pin levels |
| pin_oe | output | 90 | Pin output enables |
| irq | output | 3 | One interrupt line per bank |

## Verification
The bench builds the block with its default three banks of 30 pins, and uses the 32-bit data port.

Because 30 is less than 32, writes of all ones show that bits 31:30 are dropped. With three banks, bank index 3 falls into the unmapped space. Bank 0 can stay in level mode while bank 1 goes through edge mode, so the bench also checks that the banks stay independent.

The status-clear collision is placed in the exact cycle in which the synchronized edge appears.

// File: rtl/pio_pkg.sv
package pio_pkg;
  // register group codes, decoded from address bits 7:4
  typedef enum logic [3:0] {
    GRP_DIR  = 4'h0,
    GRP_POL  = 4'h2,
    GRP_TYP  = 4'h3,
    GRP_IEN  = 4'h4,
    GRP_STS  = 4'h5,
    GRP_BEN  = 4'h6,
    GRP_DIN  = 4'h7,
    GRP_DOUT = 4'h8
  } grp_e;

  localparam int ADDR_W = 8;
  localparam int BANK_W = 2;
endpackage

// File: rtl/pio_sync.sv
module pio_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/pio_decode.sv
module pio_decode
  import pio_pkg::*;
#(
  parameter int NUM_BANKS = 3
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output grp_e              grp,
  output logic [BANK_W-1:0] bank
);
  logic grp_ok;

  assign grp  = grp_e'(addr[7:4]);
  assign bank = addr[3:2];

  always_comb begin
    case (grp)
      GRP_DIR, GRP_POL, GRP_TYP, GRP_IEN,
      GRP_STS, GRP_BEN, GRP_DIN, GRP_DOUT: grp_ok = 1'b1;
      default:                             grp_ok = 1'b0;
    endcase
  end

  assign hit = grp_ok && (addr[1:0] == 2'b00) && (int'(bank) < NUM_BANKS);
endmodule

// File: rtl/pio_bank.sv
module pio_bank
  import pio_pkg::*;
#(
  parameter int PINS = 30
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_stb,
  input  grp_e            wr_grp,
  input  logic [PINS-1:0] wdata,
  input  logic [PINS-1:0] pin_in,
  output logic [PINS-1:0] dir_q,
  output logic [PINS-1:0] pol_q,
  output logic [PINS-1:0] typ_q,
  output logic [PINS-1:0] ien_q,
  output logic [PINS-1:0] sts_q,
  output logic [PINS-1:0] ben_q,
  output logic [PINS-1:0] dout_q,
  output logic [PINS-1:0] din_q,
  output logic            sts_wr,
  output logic            irq_q,
  output logic [PINS-1:0] pin_oe_q,
  output logic [PINS-1:0] pin_out_q
);
  logic [PINS-1:0] prev_q;
  logic [PINS-1:0] rise, fall, lvl_hit, edge_hit, evt;

  pio_sync #(.W(PINS), .STAGES(2)) u_sync (
    .clk(clk), .rst(rst), .d(pin_in), .q(din_q)
  );

  assign rise     = din_q & ~prev_q;
  assign fall     = ~din_q & prev_q;
  assign lvl_hit  = ~(din_q ^ pol_q);
  assign edge_hit = (pol_q & rise) | (~pol_q & fall);
  assign evt      = ben_q & ((typ_q & edge_hit) | (~typ_q & lvl_hit));
  assign sts_wr   = wr_stb && (wr_grp == GRP_STS);

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q     <= '1;
      pol_q     <= '0;
      typ_q     <= '0;
      ien_q     <= '0;
      sts_q     <= '0;
      ben_q     <= '0;
      dout_q    <= '0;
      prev_q    <= '0;
      irq_q     <= 1'b0;
      pin_oe_q  <= '0;
      pin_out_q <= '0;
    end else begin
      prev_q <= din_q;
      if (wr_stb) begin
        case (wr_grp)
          GRP_DIR:  dir_q  <= wdata;
          GRP_POL:  pol_q  <= wdata;
          GRP_TYP:  typ_q  <= wdata;
          GRP_IEN:  ien_q  <= wdata;
          GRP_BEN:  ben_q  <= wdata;
          GRP_DOUT: dout_q <= wdata;
          default: ;
        endcase
      end
      // event wins over a same-cycle clear
      sts_q     <= (sts_wr ? (sts_q & wdata) : sts_q) | evt;
      irq_q     <= |(dir_q & sts_q & ien_q);
      pin_oe_q  <= ben_q & ~dir_q;
      pin_out_q <= dout_q;
    end
  end
endmodule

// File: rtl/pio_multibank.sv
module pio_multibank
  import pio_pkg::*;
#(
  parameter int NUM_BANKS = 3,
  parameter int PINS      = 30,
  parameter int DATA_W    = 32
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      req_valid,
  input  logic                      req_write,
  input  logic [ADDR_W-1:0]         req_addr,
  input  logic [DATA_W-1:0]         req_wdata,
  output logic                      rd_valid,
  output logic [DATA_W-1:0]         rd_data,
  input  logic [NUM_BANKS*PINS-1:0] pin_in,
  output logic [NUM_BANKS*PINS-1:0] pin_out,
  output logic [NUM_BANKS*PINS-1:0] pin_oe,
  output logic [NUM_BANKS-1:0]      irq
);
  localparam int ALL_W = NUM_BANKS * PINS;

  logic              hit;
  grp_e              grp;
  logic [BANK_W-1:0] bank;
  logic [BANK_W-1:0] bidx;

  logic [PINS-1:0] dir_a [NUM_BANKS];
  logic [PINS-1:0] pol_a [NUM_BANKS];
  logic [PINS-1:0] typ_a [NUM_BANKS];
  logic [PINS-1:0] ien_a [NUM_BANKS];
  logic [PINS-1:0] sts_a [NUM_BANKS];
  logic [PINS-1:0] ben_a [NUM_BANKS];
  logic [PINS-1:0] dout_a[NUM_BANKS];
  logic [PINS-1:0] din_a [NUM_BANKS];

  logic [ALL_W-1:0]     dir_all, ien_all, sts_all, ben_all;
  logic [NUM_BANKS-1:0] sts_wr;

  pio_decode #(.NUM_BANKS(NUM_BANKS)) u_dec (
    .addr(req_addr), .hit(hit), .grp(grp), .bank(bank)
  );

  assign bidx = hit ? bank : '0;

  generate
    if (DATA_W > PINS) begin : g_spare
      logic unused_hi;
      assign unused_hi = ^req_wdata[DATA_W-1:PINS];
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      logic wr_stb;
      assign wr_stb = req_valid && req_write && hit && (int'(bank) == b);

      pio_bank #(.PINS(PINS)) u_bank (
        .clk(clk), .rst(rst),
        .wr_stb(wr_stb), .wr_grp(grp), .wdata(req_wdata[PINS-1:0]),
        .pin_in(pin_in[b*PINS +: PINS]),
        .dir_q(dir_a[b]), .pol_q(pol_a[b]), .typ_q(typ_a[b]),
        .ien_q(ien_a[b]), .sts_q(sts_a[b]), .ben_q(ben_a[b]),
        .dout_q(dout_a[b]), .din_q(din_a[b]),
        .sts_wr(sts_wr[b]), .irq_q(irq[b]),
        .pin_oe_q(pin_oe[b*PINS +: PINS]),
        .pin_out_q(pin_out[b*PINS +: PINS])
      );

      assign dir_all[b*PINS +: PINS] = dir_a[b];
      assign ien_all[b*PINS +: PINS] = ien_a[b];
      assign sts_all[b*PINS +: PINS] = sts_a[b];
      assign ben_all[b*PINS +: PINS] = ben_a[b];
    end
  endgenerate

  logic [PINS-1:0] rd_sel;

  always_comb begin
    rd_sel = '0;
    if (hit) begin
      case (grp)
        GRP_DIR:  rd_sel = dir_a[bidx];
        GRP_POL:  rd_sel = pol_a[bidx];
        GRP_TYP:  rd_sel = typ_a[bidx];
        GRP_IEN:  rd_sel = ien_a[bidx];
        GRP_STS:  rd_sel = sts_a[bidx];
        GRP_BEN:  rd_sel = ben_a[bidx];
        GRP_DIN:  rd_sel = din_a[bidx];
        GRP_DOUT: rd_sel = dout_a[bidx];
        default:  rd_sel = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= req_valid && !req_write;
      if (req_valid && !req_write) rd_data <= DATA_W'(rd_sel);
    end
  end
endmodule

// File: rtl/pio_multibank_chk.sv
module pio_multibank_chk #(
  parameter int NUM_BANKS = 3,
  parameter int PINS      = 30,
  parameter int DATA_W    = 32
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      req_valid,
  input logic                      req_write,
  input logic                      rd_valid,
  input logic [DATA_W-1:0]         rd_data,
  input logic [NUM_BANKS*PINS-1:0] pin_oe,
  input logic [NUM_BANKS-1:0]      irq,
  input logic [NUM_BANKS*PINS-1:0] dir_all,
  input logic [NUM_BANKS*PINS-1:0] ben_all,
  input logic [NUM_BANKS*PINS-1:0] ien_all,
  input logic [NUM_BANKS*PINS-1:0] sts_all,
  input logic [NUM_BANKS-1:0]      sts_wr
);
  assert_rdvalid_R2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_write) |=> rd_valid);

  assert_rdhigh_R2: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> (rd_data >> PINS) == '0);

  assert_oe_R3: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> pin_oe == $past(ben_all & ~dir_all));

  generate
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_chk
      assert_irq_R9: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> irq[b] == $past(|(dir_all[b*PINS +: PINS] &
                                   sts_all[b*PINS +: PINS] &
                                   ien_all[b*PINS +: PINS])));

      assert_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        !sts_wr[b] |=> ((sts_all[b*PINS +: PINS] & $past(sts_all[b*PINS +: PINS]))
                        == $past(sts_all[b*PINS +: PINS])));
    end
  endgenerate
endmodule

bind pio_multibank pio_multibank_chk #(
  .NUM_BANKS(NUM_BANKS), .PINS(PINS), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
  .rd_valid(rd_valid), .rd_data(rd_data), .pin_oe(pin_oe), .irq(irq),
  .dir_all(dir_all), .ben_all(ben_all), .ien_all(ien_all),
  .sts_all(sts_all), .sts_wr(sts_wr)
);

// File: tb/tb_pio_multibank.sv
module tb_pio_multibank;
  localparam int NB = 3;
  localparam int P  = 30;
  localparam int G_DIR = 0, G_POL = 2, G_TYP = 3, G_IEN = 4,
                 G_STS = 5, G_BEN = 6, G_DIN = 7, G_DOUT = 8;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic            rst = 1'b1;
  logic            req_valid = 1'b0, req_write = 1'b0;
  logic [7:0]      req_addr = '0;
  logic [31:0]     req_wdata = '0;
  logic            rd_valid;
  logic [31:0]     rd_data;
  logic [NB*P-1:0] pin_in = '0, pin_out, pin_oe;
  logic [NB-1:0]   irq;

  pio_multibank dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rd_valid(rd_valid),
    .rd_data(rd_data), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .irq(irq)
  );

  int checks = 0, fails = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  function automatic logic [7:0] ra(int grp, int bank);
    return 8'(grp * 16 + bank * 4);
  endfunction

  task automatic chk(logic [127:0] act, logic [127:0] exp, string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // driver: called at a negedge, returns at the next negedge
  task automatic wr(logic [7:0] a, logic [31:0] d);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, logic [31:0] exp, string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: pops expected read data as results appear
  always @(negedge clk) begin
    if (!rst && rd_valid) begin
      if (exp_q.size() == 0) chk(rd_data, 32'hDEAD, "R2 unexpected read data");
      else chk(rd_data, exp_q.pop_front(), tag_q.pop_front());
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    idle(4);
    rst = 1'b0;
    idle(1);
    // reset state
    chk(irq, 0, "R1 irq after reset");
    chk(pin_oe, 0, "R1 pin_oe after reset");
    chk(pin_out, 0, "R1 pin_out after reset");
    rd(ra(G_DIR, 0), 32'h3FFF_FFFF, "R1 direction reset");
    rd(ra(G_DOUT, 2), 0, "R1 data out reset");
    rd(ra(G_STS, 1), 0, "R1 status reset");
    // map corners
    rd(8'h10, 0, "R2 unused group");
    rd(8'h0C, 0, "R2 bank index 3");
    rd(8'h72, 0, "R2 misaligned");
    wr(ra(G_DOUT, 0), 32'hFFFF_FFFF);
    rd(ra(G_DOUT, 0), 32'h3FFF_FFFF, "R2 bits 31:30 read zero");
    // pin drive
    wr(ra(G_DIR, 0), 0);
    idle(1);
    chk(pin_oe, 0, "R3 output without pin enable");
    chk(pin_out[P-1:0], 30'h3FFF_FFFF, "R3 pin_out follows data out");
    wr(ra(G_BEN, 0), 32'h0000_FFFF);
    idle(1);
    chk(pin_oe, {60'h0, 30'h0000_FFFF}, "R3 oe = enable and not direction");
    // data in
    pin_in[3*P-1:2*P] = 30'h1234_5678;
    idle(4);
    rd(ra(G_DIN, 2), 32'h1234_5678, "R4 data in");
    wr(ra(G_DIN, 2), 0);
    rd(ra(G_DIN, 2), 32'h1234_5678, "R4 data in read-only");
    // level mode on bank 1
    wr(ra(G_POL, 1), 32'h3FFF_FFFF);
    wr(ra(G_BEN, 1), 32'h3FFF_FFFF);
    pin_in[P] = 1'b1;
    idle(5);
    rd(ra(G_STS, 1), 32'h1, "R5 level high sets status");
    wr(ra(G_STS, 1), 0);
    rd(ra(G_STS, 1), 32'h1, "R5 status sets again while level persists");
    pin_in[P] = 1'b0;
    idle(4);
    wr(ra(G_STS, 1), 0);
    rd(ra(G_STS, 1), 0, "R7 write zero clears");
    // edge mode on bank 1
    wr(ra(G_TYP, 1), 32'h3FFF_FFFF);
    wr(ra(G_POL, 1), 32'h2);
    wr(ra(G_STS, 1), 0);
    pin_in[P+1] = 1'b1;
    idle(4);
    rd(ra(G_STS, 1), 32'h2, "R6 rising edge");
    pin_in[P+2] = 1'b1;
    idle(4);
    rd(ra(G_STS, 1), 32'h2, "R6 rising ignored with falling polarity");
    wr(ra(G_STS, 1), 32'h2);
    rd(ra(G_STS, 1), 32'h2, "R7 write one keeps");
    wr(ra(G_STS, 1), 0);
    idle(3);
    rd(ra(G_STS, 1), 0, "R6 held level does not set again");
    pin_in[P+2] = 1'b0;
    idle(4);
    rd(ra(G_STS, 1), 32'h4, "R6 falling edge");
    wr(ra(G_STS, 1), 0);
    pin_in[P+1] = 1'b0;
    idle(4);
    rd(ra(G_STS, 1), 0, "R6 falling ignored with rising polarity");
    // collision: edge arrives in the cycle of the clear
    pin_in[P+1] = 1'b1;
    idle(2);
    wr(ra(G_STS, 1), 0);
    rd(ra(G_STS, 1), 32'h2, "R8 event beats clear");
    // interrupts
    wr(ra(G_IEN, 1), 32'h2);
    idle(1);
    chk(irq, 3'b010, "R9 irq raised");
    wr(ra(G_DIR, 1), 32'h3FFF_FFFD);
    idle(1);
    chk(irq, 3'b000, "R9 output pin masks irq");
    wr(ra(G_DIR, 1), 32'h3FFF_FFFF);
    idle(1);
    chk(irq, 3'b010, "R9 irq back as input");
    wr(ra(G_STS, 1), 0);
    idle(1);
    chk(irq, 3'b000, "R9 irq drops after clear");
    // independence
    rd(ra(G_STS, 0), 32'h0000_FFFF, "R10 bank0 level-low status untouched");
    rd(ra(G_POL, 0), 0, "R10 bank0 polarity untouched");
    rd(ra(G_STS, 2), 0, "R10 bank2 status untouched");
    rd(ra(G_TYP, 2), 0, "R10 bank2 type untouched");
    idle(3);
    chk(exp_q.size(), 0, "R2 every read answered");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule